// File: doc/BRIEF.md
# Direct-Write Register Window Controller

This block is the write side of a serial slave port for a small window of registers that has no staging buffer. The window holds 22 byte registers from address 0x120 to 0x135. The block takes a chip select, a serial clock and a data line, and samples all three on its own system clock. It decodes a 16-bit header into a start address. Each data byte that follows goes straight out as a one-cycle register write strobe, with its address and data. The internal pointer then advances to the next target.

The pointer wraps inside the window, so a master can stream bytes for as long as it likes. Two controls change how the pointer moves:
- When the transfer starts at one of the two port-output registers and the output-mode bit selects low-current drive, the pointer bounces between those two registers instead of climbing.
- When the serial mode is clock-idles-high, the final byte of a transfer is written when chip select rises.

A write-enable input, a protection input and a per-address read-only map decide whether a byte actually lands. Once the transfer ends, the block asks the surrounding logic to drop the write-enable bit, but only if something was written.

Top module: `regwin_direct_wr`

## Requirements
- R1: While reset is held and just after it is released, `wr_en`, `wen_clr`, `wr_addr` and `wr_data` are all 0.
- R2: A transfer is framed by `cs_n` low. Data on `mosi` is sampled on rising `sck`, most significant bit first. The first 16 bits are a header whose low 9 bits give the start address; its upper 7 bits are ignored. Every full byte after the header produces one `wr_en` pulse carrying the pointer address and the byte, provided `wen`=1, `rprot`=0 and the address is writable.
- R3: After each byte the pointer moves up by one address, and 0x135 is followed by 0x120. Transfers of any length keep writing.
- R4: Bit i of `ro_map` marks address 0x120+i as read-only. A byte aimed at a read-only address produces no strobe, but the pointer still advances past that address.
- R5: Bits left over after the last full byte when `cs_n` rises produce no write.
- R6: Some cycles after `cs_n` rises, `wen_clr` pulses for exactly one cycle, and only if the transfer produced at least one write. Otherwise it stays 0.
- R7: With `rprot`=1, no byte is written and `wen_clr` stays 0.
- R8: If the start address is 0x120 or 0x121 and `pio_hicur`=0, the pointer alternates between 0x120 and 0x121 after each byte. With `pio_hicur`=1 it climbs as in R3.
- R9: With `mode11`=0 (clock idles low), a byte is committed on the falling `sck` edge that follows its last bit. A byte whose last bit gets no falling edge before `cs_n` rises is dropped.
- R10: With `mode11`=1 (clock idles high), every byte except the last is committed on the falling `sck` edge that follows its last bit. The last full byte is committed when `cs_n` rises.
- R11: A start address outside 0x120..0x135 discards every data byte of the transfer, and `wen_clr` stays 0.
- R12: With `wen`=0, no byte is written and `wen_clr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| mode11 | input | 1 | 1 selects the clock-idles-high serial mode, 0 the clock-idles-low mode |
| wen | input | 1 | Write-enable bit |
| rprot | input | 1 | Write protection for the window |
| pio_hicur | input | 1 | Port output mode; 0 selects low-current mode and enables the two-register bounce |
| ro_map | input | 22 | Read-only flag per window address, bit i for 0x120+i |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 9 | Address of the register being written |
| wr_data | output | 8 | Data byte being written |
| wen_clr | output | 1 | One-cycle request to clear the write-enable bit |

## Verification
The main sweep runs every start address from two below the window to two above it. Each run streams 24 bytes under a fixed read-only pattern. This separates in-window starts from rejected ones, shows the wrap from 0x135 to 0x120, and shows that read-only slots are skipped without stalling the pointer.

Targeted transfers then vary the surrounding conditions:
- The two-register bounce is tried under both output modes and from both of its start addresses.
- Trailing partial bits are tried in both serial modes.
- Ending mode-(0,0) transfers with and without a final falling clock edge separates the two commit rules.
- Transfers with protection set and with write-enable clear show that no write happens and no clear request is raised.

// File: rtl/regwin_direct_wr.sv
module regwin_direct_wr #(
  parameter int unsigned AW   = 9,
  parameter int unsigned BASE = 'h120,
  parameter int unsigned WIN  = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic          mode11,
  input  logic          wen,
  input  logic          rprot,
  input  logic          pio_hicur,
  input  logic [WIN-1:0] ro_map,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wen_clr
);
  localparam int unsigned PW = $clog2(WIN);
  localparam logic [AW:0]   LO = (AW+1)'(BASE);
  localparam logic [AW:0]   HI = (AW+1)'(BASE + WIN);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [PW-1:0] LAST = PW'(WIN - 1);

  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  wire sel     = ~cs_q[1];
  wire sck_r   = sck_q[1] & ~sck_q[2] & sel;
  wire sck_f   = ~sck_q[1] & sck_q[2] & sel;
  wire cs_fall = ~cs_q[1] & cs_q[2];
  wire cs_rise = cs_q[1] & ~cs_q[2];
  wire bit_in  = mosi_q[1];

  logic          hdr, pend, valid, pp, wrote;
  logic [3:0]    cnt;
  logic [15:0]   sh;
  logic [PW-1:0] ptr;

  wire [AW-1:0] addr_in  = {sh[AW-2:0], bit_in};
  wire          in_win   = ({1'b0, addr_in} >= LO) && ({1'b0, addr_in} < HI);
  wire          commit   = pend && (sck_f || (cs_rise && mode11));
  wire          ok       = commit && valid && wen && !rprot && !ro_map[ptr];
  wire [PW-1:0] ptr_nxt  = pp ? {ptr[PW-1:1], ~ptr[0]}
                              : (ptr == LAST ? '0 : ptr + 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hdr   <= 1'b1;
      pend  <= 1'b0;
      valid <= 1'b0;
      pp    <= 1'b0;
      wrote <= 1'b0;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= '0;
    end else if (cs_fall) begin
      hdr   <= 1'b1;
      pend  <= 1'b0;
      valid <= 1'b0;
      wrote <= 1'b0;
      cnt   <= '0;
    end else begin
      if (ok) wrote <= 1'b1;
      if (commit) ptr <= ptr_nxt;
      if (commit || cs_rise) pend <= 1'b0;
      if (sck_r) begin
        sh  <= {sh[14:0], bit_in};
        cnt <= cnt + 1'b1;
        if (hdr && cnt == 4'd15) begin
          hdr   <= 1'b0;
          cnt   <= '0;
          valid <= in_win;
          ptr   <= in_win ? PW'(addr_in - BASE_A) : '0;
          pp    <= in_win && (addr_in - BASE_A) < 2 && !pio_hicur;
        end else if (!hdr && cnt == 4'd7) begin
          cnt  <= '0;
          pend <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wen_clr <= 1'b0;
    end else begin
      wr_en   <= ok;
      wen_clr <= cs_rise && (wrote || ok);
      if (ok) begin
        wr_addr <= BASE_A + AW'(ptr);
        wr_data <= sh[7:0];
      end
    end
endmodule

module regwin_direct_wr_chk #(
  parameter int unsigned AW   = 9,
  parameter int unsigned BASE = 'h120,
  parameter int unsigned WIN  = 22
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wen,
  input logic           rprot,
  input logic [WIN-1:0] ro_map,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic           wen_clr
);
  logic [WIN-1:0] ro_q;
  always_ff @(posedge clk) ro_q <= ro_map;
  wire [AW-1:0] off = wr_addr - AW'(BASE);

  p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (off < AW'(WIN)));
  p_ro_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !ro_q[off[$clog2(WIN)-1:0]]);
  p_clr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clr |=> !wen_clr);
  p_no_write_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(rprot));
  p_no_write_wen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(wen));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !wr_en && !wen_clr);
endmodule

bind regwin_direct_wr regwin_direct_wr_chk #(.AW(AW), .BASE(BASE), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wen(wen), .rprot(rprot), .ro_map(ro_map),
  .wr_en(wr_en), .wr_addr(wr_addr), .wen_clr(wen_clr));

// File: tb/sim_regwin_direct_wr.sv
module sim_regwin_direct_wr;
  localparam int CLK_P = 10;
  localparam int H = 4 * CLK_P;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic mode11 = 0, wen = 1, rprot = 0, pio_hicur = 0;
  logic [21:0] ro_map = '0;
  logic wr_en, wen_clr;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0, failures = 0;
  int nact = 0, nclr = 0;
  logic [8:0] act_a [0:255];
  logic [7:0] act_d [0:255];

  always #(CLK_P/2) clk = ~clk;

  regwin_direct_wr u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .mode11(mode11), .wen(wen), .rprot(rprot), .pio_hicur(pio_hicur), .ro_map(ro_map),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wen_clr(wen_clr));

  always @(negedge clk) begin
    if (wr_en) begin
      if (nact < 256) begin act_a[nact] = wr_addr; act_d[nact] = wr_data; end
      nact++;
    end
    if (wen_clr) nclr++;
  end

  task automatic check(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [8:0] a, input int k);
    return 8'((a * 7 + k * 13 + 5) & 'hFF);
  endfunction

  task automatic frame(input logic [8:0] a, input int nb, input int extra,
                       input bit m11, input bit nofall, input string tag);
    int total = 16 + 8 * nb + extra;
    logic [15:0] hd = {7'h01, a};
    logic [8:0] ea [0:255];
    logic [7:0] ed [0:255];
    int ne = 0, ncom, p;
    bit vld, ppm, bad = 0;
    mode11 = m11;
    sck = m11;
    nact = 0; nclr = 0;
    #H;
    cs_n = 0;
    #H;
    for (int i = 0; i < total; i++) begin
      logic b;
      if (i < 16) b = hd[15 - i];
      else b = dbyte(a, (i - 16) / 8)[7 - ((i - 16) % 8)];
      if (m11) begin
        sck = 0; mosi = b; #H; sck = 1; #H;
      end else begin
        mosi = b; #H; sck = 1; #H;
        if (!(nofall && i == total - 1)) sck = 0;
      end
    end
    #H;
    cs_n = 1;
    if (nofall) begin #H; sck = 0; end
    repeat (12) @(negedge clk);

    vld = (a >= 9'h120) && (a <= 9'h135);
    ppm = vld && (a == 9'h120 || a == 9'h121) && !pio_hicur;
    ncom = (extra > 0 || m11 || !nofall) ? nb : nb - 1;
    p = vld ? int'(a) - 'h120 : 0;
    for (int k = 0; k < ncom; k++) begin
      if (vld && wen && !rprot && !ro_map[p]) begin
        ea[ne] = 9'('h120 + p); ed[ne] = dbyte(a, k); ne++;
      end
      if (ppm) p = p ^ 1;
      else p = (p == 21) ? 0 : p + 1;
    end
    check(nact == ne, {tag, " write count"}, nact, ne);
    for (int k = 0; k < ne && k < nact; k++)
      if (!bad && (act_a[k] != ea[k] || act_d[k] != ed[k])) begin
        bad = 1;
        check(0, {tag, " write content"}, {act_a[k], act_d[k]}, {ea[k], ed[k]});
      end
    if (!bad) check(1, tag, 0, 0);
    check(nclr == (ne > 0 ? 1 : 0), {tag, " R6 clear request"}, nclr, ne > 0 ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wr_en == 0 && wen_clr == 0, "R1 reset strobes", {wr_en, wen_clr}, 0);
    rst_n = 1;
    @(negedge clk);
    check(wr_addr == 0 && wr_data == 0, "R1 reset data", {wr_addr, wr_data}, 0);

    ro_map = 22'h0A0481;
    pio_hicur = 1;
    for (int a = 'h11E; a <= 'h137; a++)
      frame(9'(a), 24, 0, 0, 0, "R2 R3 R4 R11 sweep");

    ro_map = '0;
    pio_hicur = 0;
    frame(9'h120, 5, 0, 1, 0, "R8 bounce 120");
    frame(9'h121, 5, 0, 0, 0, "R8 bounce 121");
    frame(9'h122, 4, 0, 0, 0, "R8 no bounce at 122");
    pio_hicur = 1;
    frame(9'h120, 5, 0, 1, 0, "R8 high-current climbs");

    frame(9'h124, 3, 5, 0, 0, "R5 partial mode00");
    frame(9'h124, 3, 3, 1, 0, "R5 partial mode11");
    frame(9'h130, 0, 6, 0, 0, "R5 R6 only partial");

    frame(9'h128, 3, 0, 0, 1, "R9 no final fall drops last");
    frame(9'h128, 1, 0, 0, 1, "R9 single byte dropped");
    frame(9'h128, 3, 0, 0, 0, "R9 final fall commits");
    frame(9'h12A, 3, 0, 1, 0, "R10 last byte at cs rise");
    frame(9'h12A, 1, 0, 1, 0, "R10 single byte mode11");

    rprot = 1;
    frame(9'h125, 4, 0, 0, 0, "R7 protected");
    rprot = 0;
    wen = 0;
    frame(9'h125, 4, 0, 1, 0, "R12 write disabled");
    wen = 1;
    ro_map = '1;
    frame(9'h120, 3, 0, 0, 0, "R4 R6 all read-only");
    ro_map = '0;
    frame(9'h1FF, 3, 0, 0, 0, "R11 far outside");
    frame(9'h135, 60, 0, 1, 0, "R3 long stream");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule